// File: doc/BRIEF.md
# Segment Access Limit and Protection Checker

This block decides whether a memory access, described by its linear address, byte count and kind (read, write or instruction fetch), is allowed by the cached state of the segment it goes through. It works for the legacy and compatibility modes of the processor. When long mode is active and the code segment runs 64-bit code, every check is skipped and the access passes. Otherwise the block first rejects a null selector. Then, for the data-class segment indices only, it applies the write and read permissions. Finally it compares both the first and the last byte offset of the access against the segment limit. That comparison uses the normal sense for ordinary segments and the inverted sense for expand-down segments. Every rejection is a general-protection fault with error code zero, reported as the single `rsp_fault` bit.

The effective offset is the linear address minus the segment base, truncated to 16 or 32 bits. The width comes from the code segment default-size bit combined with the per-access address-size override.

Requests enter on a valid/ready port and results leave on a valid/ready port through one register stage. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Its result is presented in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and `req_ready` is low, so back-pressure reaches the requester in the same cycle. All descriptor fields must be held valid alongside `req_valid`.

Top module: `seg_access_check`

## Requirements
- R1: When `mode_lma` and `cs_long` are both 1, an accepted access always yields `rsp_fault`=0, whatever the selector, attributes or limit are.
- R2: Outside the R1 bypass, a `seg_sel` value of zero yields `rsp_fault`=1 even if all other checks would pass.
- R3: For a data-class segment (index from DATA_LO to DATA_HI, default 0 to 6), a write (`req_kind`=1) with `attr_wr`=0 faults, and a write with `attr_wr`=1 is not rejected by permission.
- R4: For a data-class segment, a plain read (`req_kind`=0) with `attr_rd`=0 faults, and an instruction fetch (`req_kind`=2) with `attr_rd`=0 is not rejected by permission.
- R5: For a segment index outside the data class, `attr_wr`, `attr_rd` and `attr_down` have no effect: the access is checked as a normal segment with no permission checks.
- R6: The offset width is 16 bits when `cs_big` equals `req_asz_ovr`, otherwise 32 bits. The offset is (`req_addr` − `seg_base`) modulo 2^width.
- R7: For a normal segment, the end offset is offset + `req_bytes` − 1, computed without wrap (`req_bytes` ≥ 1). The access faults if the offset or the end offset exceeds `seg_limit`.
- R8: For an expand-down data-class segment (`attr_down`=1), the access faults if the offset or the end offset is less than or equal to `seg_limit`.
- R9: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. The result of a request accepted at one edge is valid after that edge. A stalled result keeps `rsp_valid` and `rsp_fault` stable. Synchronous reset clears `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Linear address of the first byte |
| req_bytes | input | SIZE_W | Access size in bytes, at least 1 |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_seg | input | SEG_W | Segment register index |
| req_asz_ovr | input | 1 | Address-size override on this access |
| seg_sel | input | SEL_W | Selector currently in the segment register |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| attr_wr | input | 1 | Segment writable |
| attr_rd | input | 1 | Segment readable |
| attr_down | input | 1 | Segment expands downward |
| cs_big | input | 1 | Code segment default operand/address size is 32-bit |
| mode_lma | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is a 64-bit segment |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | General-protection fault, error code zero |

## Verification
A corrupted output register or a wrong handshake flag shows at the ports within one cycle. A result appears without a matching request, a scoreboard entry goes missing, or a held result changes while `rsp_ready` is low. A wrong offset width or a wrong end-offset carry does not show for most requests. It shows only for requests placed next to a limit or across a 16-bit wrap, so the stimulus places accesses exactly at, just under and just over each limit. A stale permission decision shows on the very next response for which write, read and fetch disagree.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic down;
  } seg_attr_t;
endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SIZE_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] bytes,
  input  logic              narrow,
  output logic [ADDR_W-1:0] first_off,
  output logic [ADDR_W:0]   last_off
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [ADDR_W-1:0] diff;
  logic [ADDR_W:0]   span;

  always_comb begin
    diff      = addr - base;
    first_off = narrow ? (diff & NARROW_MASK) : diff;
    span      = {{(ADDR_W+1-SIZE_W){1'b0}}, bytes};
    last_off  = {1'b0, first_off} + span - {{ADDR_W{1'b0}}, 1'b1};
  end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEG_W   = 4,
  parameter int DATA_LO = 0,
  parameter int DATA_HI = 6
) (
  input  logic [ADDR_W-1:0] first_off,
  input  logic [ADDR_W:0]   last_off,
  input  logic [ADDR_W-1:0] limit,
  input  acc_kind_e         kind,
  input  logic [SEG_W-1:0]  seg_idx,
  input  seg_attr_t         attr,
  input  logic              sel_null,
  input  logic              bypass,
  output logic              fault
);
  logic            data_cls;
  logic            perm_bad;
  logic            down_eff;
  logic [ADDR_W:0] lim_x;
  logic            first_hi;
  logic            last_hi;
  logic            range_bad;

  always_comb begin
    data_cls  = (int'(seg_idx) >= DATA_LO) && (int'(seg_idx) <= DATA_HI);
    perm_bad  = data_cls && (((kind == ACC_WRITE) && !attr.wr) ||
                             ((kind == ACC_READ)  && !attr.rd));
    down_eff  = data_cls && attr.down;
    lim_x     = {1'b0, limit};
    first_hi  = {1'b0, first_off} > lim_x;
    last_hi   = last_off > lim_x;
    range_bad = down_eff ? (!first_hi || !last_hi) : (first_hi || last_hi);
    if (bypass)        fault = 1'b0;
    else if (sel_null) fault = 1'b1;
    else               fault = perm_bad || range_bad;
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SIZE_W   = 4,
  parameter int SEG_W    = 4,
  parameter int SEL_W    = 16,
  parameter int DATA_LO  = 0,
  parameter int DATA_HI  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_bytes,
  input  logic [1:0]        req_kind,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              req_asz_ovr,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              attr_wr,
  input  logic              attr_rd,
  input  logic              attr_down,
  input  logic              cs_big,
  input  logic              mode_lma,
  input  logic              cs_long,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault
);
  logic [ADDR_W-1:0] first_off;
  logic [ADDR_W:0]   last_off;
  logic              narrow;
  logic              bypass;
  logic              sel_null;
  logic              fault_d;
  logic              fire;
  logic              valid_q;
  logic              fault_q;
  seg_attr_t         attr;
  acc_kind_e         kind;

  always_comb begin
    narrow    = (cs_big == req_asz_ovr);
    bypass    = mode_lma && cs_long;
    sel_null  = (seg_sel == '0);
    attr      = '{wr: attr_wr, rd: attr_rd, down: attr_down};
    kind      = acc_kind_e'(req_kind);
    req_ready = !valid_q || rsp_ready;
    fire      = req_valid && req_ready;
  end

  seg_offset_calc #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .SIZE_W(SIZE_W)
  ) u_off (
    .addr(req_addr), .base(seg_base), .bytes(req_bytes), .narrow(narrow),
    .first_off(first_off), .last_off(last_off)
  );

  seg_rule_eval #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .DATA_LO(DATA_LO), .DATA_HI(DATA_HI)
  ) u_rule (
    .first_off(first_off), .last_off(last_off), .limit(seg_limit),
    .kind(kind), .seg_idx(req_seg), .attr(attr), .sel_null(sel_null),
    .bypass(bypass), .fault(fault_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (fire) begin
      valid_q <= 1'b1;
      fault_q <= fault_d;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_fault = fault_q;

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_lma && cs_long) |=> (rsp_valid && !rsp_fault)); // R1
  AST_NULL_FAULT: assert property (@(posedge clk) disable iff (rst)
    (fire && !(mode_lma && cs_long) && (seg_sel == '0)) |=> rsp_fault); // R2
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (fire && !(mode_lma && cs_long) && (int'(req_seg) >= DATA_LO) &&
     (int'(req_seg) <= DATA_HI) && (req_kind == 2'd1) && !attr_wr) |=> rsp_fault); // R3
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault))); // R9
endmodule

// File: tb/sim_seg_access_check.sv
module sim_seg_access_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_bytes = 4'd1;
  logic [1:0]  req_kind = '0;
  logic [3:0]  req_seg = '0;
  logic        req_asz_ovr = 1'b0;
  logic [15:0] seg_sel = '0;
  logic [31:0] seg_base = '0;
  logic [31:0] seg_limit = '0;
  logic        attr_wr = 1'b0, attr_rd = 1'b0, attr_down = 1'b0;
  logic        cs_big = 1'b0, mode_lma = 1'b0, cs_long = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    drv_done = 1'b0;
  bit    stall_seen = 1'b0;

  always #2 clk = ~clk;

  seg_access_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_kind(req_kind),
    .req_seg(req_seg), .req_asz_ovr(req_asz_ovr), .seg_sel(seg_sel),
    .seg_base(seg_base), .seg_limit(seg_limit), .attr_wr(attr_wr),
    .attr_rd(attr_rd), .attr_down(attr_down), .cs_big(cs_big),
    .mode_lma(mode_lma), .cs_long(cs_long), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault)
  );

  function automatic bit ref_fault(input logic [31:0] a, input logic [3:0] n,
      input logic [1:0] k, input logic [3:0] s, input bit ovr, input logic [15:0] sel,
      input logic [31:0] b, input logic [31:0] l, input bit w, input bit r,
      input bit d, input bit big, input bit lma, input bit l64);
    logic [32:0] off, last;
    bit dcls, dn;
    if (lma && l64) return 1'b0;                      // R1
    if (sel == 16'd0) return 1'b1;                    // R2
    dcls = (s <= 4'd6);
    if (dcls && k == 2'd1 && !w) return 1'b1;         // R3
    if (dcls && k == 2'd0 && !r) return 1'b1;         // R4
    dn = dcls && d;                                   // R5
    off = {1'b0, a - b};
    if (big == ovr) off = off & 33'h0_0000_FFFF;      // R6
    last = off + {29'd0, n} - 33'd1;                  // R7
    if (dn) return (off <= {1'b0, l}) || (last <= {1'b0, l}); // R8
    return (off > {1'b0, l}) || (last > {1'b0, l});
  endfunction

  task automatic issue(input string tag, input logic [31:0] a, input logic [3:0] n,
      input logic [1:0] k, input logic [3:0] s, input bit ovr, input logic [15:0] sel,
      input logic [31:0] b, input logic [31:0] l, input bit w, input bit r,
      input bit d, input bit big, input bit lma, input bit l64);
    req_addr = a; req_bytes = n; req_kind = k; req_seg = s; req_asz_ovr = ovr;
    seg_sel = sel; seg_base = b; seg_limit = l; attr_wr = w; attr_rd = r;
    attr_down = d; cs_big = big; mode_lma = lma; cs_long = l64;
    req_valid = 1'b1;
    exp_q.push_back(ref_fault(a, n, k, s, ovr, sel, b, l, w, r, d, big, lma, l64));
    tag_q.push_back(tag);
    forever begin
      #1;
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Monitor: back-pressure pattern, scoreboard compare, stall hold check (R9)
  initial begin
    int  cyc = 0;
    bit  held_v = 1'b0;
    bit  held_f = 1'b0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      rsp_ready = ((cyc % 5) != 3) && ((cyc % 7) != 5);
      cyc++;
      #1;
      if (held_v) begin
        n_tests++;
        if (!rsp_valid || rsp_fault !== held_f) begin
          n_fail++;
          $display("FAIL R9 stalled result changed: valid=%0b fault=%0b expected valid=1 fault=%0b",
                   rsp_valid, rsp_fault, held_f);
        end
      end
      held_v = rsp_valid && !rsp_ready;
      held_f = rsp_fault;
      if (held_v) stall_seen = 1'b1;
      if (rsp_valid && rsp_ready) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected result: fault=%0b expected no result", rsp_fault);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rsp_fault !== e) begin
            n_fail++;
            $display("FAIL %s: fault=%0b expected %0b", t, rsp_fault, e);
          end
        end
      end
      @(negedge clk);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_tests++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 reset: valid=%0b ready=%0b expected valid=0 ready=1", rsp_valid, req_ready);
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 bypass with null selector and read-only write over limit
    issue("R1 bypass", 32'hFFFF_0000, 4'd4, 2'd1, 4'd3, 1'b0, 16'h0, 32'h0, 32'h10, 0, 0, 0, 1, 1, 1);
    issue("R1 lma only no bypass", 32'h10, 4'd1, 2'd0, 4'd3, 1'b0, 16'h0, 32'h0, 32'hFFFF, 1, 1, 0, 1, 1, 0);
    // R2 null selector
    issue("R2 null sel", 32'h10, 4'd1, 2'd0, 4'd3, 1'b1, 16'h0, 32'h0, 32'hFFFF, 1, 1, 0, 1, 0, 0);
    issue("R2 nonnull ok", 32'h10, 4'd1, 2'd0, 4'd3, 1'b1, 16'h8, 32'h0, 32'hFFFF, 1, 1, 0, 1, 0, 0);
    // R3 write permission
    issue("R3 write ro", 32'h100, 4'd2, 2'd1, 4'd3, 1'b1, 16'h10, 32'h0, 32'hFFFF, 0, 1, 0, 1, 0, 0);
    issue("R3 write rw", 32'h100, 4'd2, 2'd1, 4'd3, 1'b1, 16'h10, 32'h0, 32'hFFFF, 1, 1, 0, 1, 0, 0);
    // R4 read permission
    issue("R4 read unreadable", 32'h100, 4'd1, 2'd0, 4'd1, 1'b1, 16'h10, 32'h0, 32'hFFFF, 1, 0, 0, 1, 0, 0);
    issue("R4 fetch unreadable", 32'h100, 4'd1, 2'd2, 4'd1, 1'b1, 16'h10, 32'h0, 32'hFFFF, 0, 0, 0, 1, 0, 0);
    // R5 non-data segment ignores attributes
    issue("R5 write ro idx8", 32'h100, 4'd4, 2'd1, 4'd8, 1'b1, 16'h10, 32'h0, 32'hFFFF, 0, 0, 0, 1, 0, 0);
    issue("R5 down ignored idx9", 32'h100, 4'd4, 2'd0, 4'd9, 1'b1, 16'h10, 32'h0, 32'hFFFF, 0, 0, 1, 1, 0, 0);
    // R6 offset width select
    issue("R6 16bit big0 ovr0", 32'h0001_2345, 4'd1, 2'd0, 4'd3, 1'b0, 16'h10, 32'h0, 32'h3000, 1, 1, 0, 0, 0, 0);
    issue("R6 32bit big0 ovr1", 32'h0001_2345, 4'd1, 2'd0, 4'd3, 1'b1, 16'h10, 32'h0, 32'h3000, 1, 1, 0, 0, 0, 0);
    issue("R6 16bit big1 ovr1", 32'h0001_2345, 4'd1, 2'd0, 4'd3, 1'b1, 16'h10, 32'h0, 32'h3000, 1, 1, 0, 1, 0, 0);
    issue("R6 16bit wrap", 32'h0000_0010, 4'd1, 2'd0, 4'd3, 1'b0, 16'h10, 32'h20, 32'hFFF0, 1, 1, 0, 0, 0, 0);
    // R7 normal limit boundaries
    issue("R7 last byte at limit", 32'h1FFF, 4'd1, 2'd0, 4'd3, 1'b1, 16'h10, 32'h1000, 32'h0FFF, 1, 1, 0, 1, 0, 0);
    issue("R7 end over limit", 32'h1FFE, 4'd4, 2'd0, 4'd3, 1'b1, 16'h10, 32'h1000, 32'h0FFF, 1, 1, 0, 1, 0, 0);
    issue("R7 end exactly limit", 32'h1FFC, 4'd4, 2'd1, 4'd3, 1'b1, 16'h10, 32'h1000, 32'h0FFF, 1, 1, 0, 1, 0, 0);
    issue("R7 start over limit", 32'h2000, 4'd1, 2'd0, 4'd3, 1'b1, 16'h10, 32'h1000, 32'h0FFF, 1, 1, 0, 1, 0, 0);
    issue("R7 end past 16bit top", 32'hFFFE, 4'd4, 2'd0, 4'd3, 1'b0, 16'h10, 32'h0, 32'hFFFF, 1, 1, 0, 0, 0, 0);
    // R8 expand-down
    issue("R8 down above limit", 32'h0101, 4'd2, 2'd0, 4'd2, 1'b1, 16'h10, 32'h0, 32'h0100, 1, 1, 1, 1, 0, 0);
    issue("R8 down at limit", 32'h0100, 4'd1, 2'd0, 4'd2, 1'b1, 16'h10, 32'h0, 32'h0100, 1, 1, 1, 1, 0, 0);
    issue("R8 down below limit", 32'h0080, 4'd4, 2'd1, 4'd2, 1'b1, 16'h10, 32'h0, 32'h0100, 1, 1, 1, 1, 0, 0);
    // R9 back-to-back traffic under back-pressure
    for (int i = 0; i < 24; i++) begin
      issue("R9 stream", 32'h0FF8 + 32'(i), 4'd4, 2'(i % 3), 4'(i % 10), 1'b1, 16'h10,
            32'h0, 32'h0FFF, bit'(i % 2), bit'((i / 2) % 2), bit'((i / 5) % 2), 1, 0, 0);
    end
    drv_done = 1'b1;
  end

  initial begin
    int wd = 0;
    while (!(drv_done && exp_q.size() == 0) && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    repeat (4) @(negedge clk);
    if (wd >= 20000) begin
      n_fail++;
      $display("FAIL R9 watchdog: pending=%0d expected 0", exp_q.size());
    end
    n_tests++;
    if (!stall_seen) begin
      n_fail++;
      $display("FAIL R9 no stall observed: seen=0 expected 1");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule